// File: doc/BRIEF.md
# Byte-Packing Transfer Data Buffer

This block sits between a 16-bit host data port and a byte-serial bus engine. One small byte shift register holds the data in both directions. The host loads transmit data two bytes at a time, or one byte for the trailing odd byte. The engine then takes the bytes out one at a time, oldest first. In the receive direction the engine deposits bytes one at a time and the host collects them in pairs. A byte-order input selects how the two bytes of a host word map onto the buffer. The mapping differs between writes and reads, so that a host using either order sees bytes in bus order.

The transmit and receive directions keep separate fill counters but share the storage. The block reports transmit underflow, receive overrun, transmit-ready and receive-ready as sticky flags to a status unit. A read that finds only one byte pending raises a one-cycle pulse. A host access and an engine access may land in the same cycle. The host access takes effect first and the engine access then acts on the result.

Top module: `bpb_buffer`

## Requirements
- R1: A word write (host_wr=1, host_wr_byte=0) accepted with tx_count <= 2 shifts the buffer up by 16 bits and adds 2 to tx_count. The buffer's byte k is bits 8k+7:8k. With big_endian=0, host_wdata[7:0] becomes byte 1 and host_wdata[15:8] becomes byte 0. With big_endian=1, host_wdata[15:8] becomes byte 1 and host_wdata[7:0] becomes byte 0.
- R2: A host write of either size that arrives while tx_count is above 2 is discarded. The buffer, tx_count and the flags are left unchanged.
- R3: A byte write (host_wr=1, host_wr_byte=1) shifts the buffer up by 8 bits, places host_wdata[7:0] in byte 0 and adds 1 to tx_count.
- R4: eng_tx_data shows byte (tx_count-1) of the buffer. An engine pop with tx_count > 0 decrements tx_count. A pop with tx_count = 0 sets tx_underflow, presents 0 and leaves tx_count at 0.
- R5: Every engine pop sets tx_ready. Every accepted host write clears tx_underflow. An accepted host write also clears tx_ready when it leaves tx_count above 2.
- R6: An engine push with rx_count < 4 stores eng_rx_data in byte rx_count and increments rx_count. With rx_count = 4 the push sets rx_overrun, the byte is lost and rx_count stays 4. Every push sets rx_ready.
- R7: host_rdata shows buffer bytes 0 and 1. With big_endian=0, host_rdata[7:0] is byte 0 and host_rdata[15:8] is byte 1. With big_endian=1 the two bytes trade places.
- R8: A host read (host_rd=1, host_wr=0) changes rx_count as follows. From 1 it goes to 0 and rd_single pulses high for one cycle. From 2 it goes to 0. Above 2 the buffer shifts down by 16 bits, fills with zeros, and rx_count drops by 2. At 0 it stays 0.
- R9: Every host read clears rx_overrun. A host read that leaves rx_count at 0 clears rx_ready.
- R10: When host and engine act in the same cycle, the host access is applied first and the engine access acts on its result. A flag set by the engine wins over a clear by the host.
- R11: After reset the buffer, both counts and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Host byte-order select |
| host_wr | input | 1 | Host write strobe (takes precedence over host_rd) |
| host_wr_byte | input | 1 | Qualifies host_wr as a single-byte write |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read data, valid in the strobe cycle |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_data | output | 8 | Next transmit byte |
| eng_rx_push | input | 1 | Engine delivers one receive byte |
| eng_rx_data | input | 8 | Received byte |
| tx_count | output | 3 | Transmit bytes pending |
| rx_count | output | 3 | Receive bytes pending |
| tx_underflow | output | 1 | Engine popped an empty transmit side |
| rx_overrun | output | 1 | Engine pushed into a full receive side |
| tx_ready | output | 1 | Transmit side wants data |
| rx_ready | output | 1 | Receive side holds data |
| rd_single | output | 1 | One-cycle pulse after a read that found one byte |

## Verification
The bench checks the pop order of word writes under both byte orders. A design with the write swizzle inverted would send each pair reversed. It loads the buffer past the write limit in two ways. A design whose limit is off by one would corrupt a queued byte or lose a write it should have accepted. Reads are checked from counts of 4, 3, 2, 1 and 0. A wrong shift or count step would return stale bytes or leave rx_ready stuck high. Same-cycle host and engine accesses are also covered. Applying them in the wrong order would make a pop after a write report underflow, or make a push after a read from a full buffer report overrun.

// File: rtl/bpb_pkg.sv
package bpb_pkg;

   typedef enum logic [1:0] {
      HOP_NONE,
      HOP_WORD,
      HOP_BYTE,
      HOP_READ
   } bpb_host_op_e;

   typedef struct packed {
      logic tx_underflow;
      logic rx_overrun;
      logic tx_ready;
      logic rx_ready;
   } bpb_flags_t;

endpackage

// File: rtl/bpb_order_swap.sv
module bpb_order_swap #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 2
) (
   input  logic [BYTE_W*LANES-1:0] din,
   input  logic                    swap,
   output logic [BYTE_W*LANES-1:0] dout
);
   generate
      if (LANES == 1) begin : g_single
         logic unused_swap;
         assign unused_swap = swap;
         assign dout = din;
      end else begin : g_multi
         logic [BYTE_W*LANES-1:0] rev;
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign rev[i*BYTE_W +: BYTE_W] = din[(LANES-1-i)*BYTE_W +: BYTE_W];
         end
         assign dout = swap ? rev : din;
      end
   endgenerate
endmodule

// File: rtl/bpb_host_stage.sv
module bpb_host_stage
   import bpb_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int HOST_BYTES  = 2,
   parameter int DEPTH_BYTES = 4,
   parameter int CNT_W       = 3
) (
   input  bpb_host_op_e                    op,
   input  logic [BYTE_W*HOST_BYTES-1:0]    word_in,
   input  logic [BYTE_W-1:0]               byte_in,
   input  logic [BYTE_W*DEPTH_BYTES-1:0]   buf_q,
   input  logic [CNT_W-1:0]                tx_q,
   input  logic [CNT_W-1:0]                rx_q,
   output logic [BYTE_W*DEPTH_BYTES-1:0]   buf_h,
   output logic [CNT_W-1:0]                tx_h,
   output logic [CNT_W-1:0]                rx_h,
   output logic                            clr_udf,
   output logic                            clr_txrdy,
   output logic                            clr_ovr,
   output logic                            clr_rxrdy,
   output logic                            short_rd
);
   localparam int               BUF_W  = BYTE_W * DEPTH_BYTES;
   localparam int               HOST_W = BYTE_W * HOST_BYTES;
   localparam logic [CNT_W-1:0] HB_C   = CNT_W'(HOST_BYTES);
   localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(DEPTH_BYTES - HOST_BYTES);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   always_comb begin
      buf_h     = buf_q;
      tx_h      = tx_q;
      rx_h      = rx_q;
      clr_udf   = 1'b0;
      clr_txrdy = 1'b0;
      clr_ovr   = 1'b0;
      clr_rxrdy = 1'b0;
      short_rd  = 1'b0;
      unique case (op)
         HOP_WORD: begin
            if (tx_q <= LIM_C) begin
               buf_h     = {buf_q[BUF_W-HOST_W-1:0], word_in};
               tx_h      = tx_q + HB_C;
               clr_udf   = 1'b1;
               clr_txrdy = (tx_h > HB_C);
            end
         end
         HOP_BYTE: begin
            if (tx_q <= LIM_C) begin
               buf_h     = {buf_q[BUF_W-BYTE_W-1:0], byte_in};
               tx_h      = tx_q + ONE_C;
               clr_udf   = 1'b1;
               clr_txrdy = (tx_h > HB_C);
            end
         end
         HOP_READ: begin
            clr_ovr = 1'b1;
            if (rx_q > HB_C) begin
               buf_h = buf_q >> HOST_W;
               rx_h  = rx_q - HB_C;
            end else begin
               short_rd = (rx_q != '0) && (rx_q < HB_C);
               rx_h     = '0;
            end
            clr_rxrdy = (rx_h == '0);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/bpb_engine_stage.sv
module bpb_engine_stage #(
   parameter int BYTE_W      = 8,
   parameter int DEPTH_BYTES = 4,
   parameter int CNT_W       = 3
) (
   input  logic                            pop,
   input  logic                            push,
   input  logic [BYTE_W-1:0]               push_data,
   input  logic [BYTE_W*DEPTH_BYTES-1:0]   buf_h,
   input  logic [CNT_W-1:0]                tx_h,
   input  logic [CNT_W-1:0]                rx_h,
   output logic [BYTE_W*DEPTH_BYTES-1:0]   buf_e,
   output logic [CNT_W-1:0]                tx_e,
   output logic [CNT_W-1:0]                rx_e,
   output logic [BYTE_W-1:0]               tx_data,
   output logic                            set_udf,
   output logic                            set_ovr,
   output logic                            set_txrdy,
   output logic                            set_rxrdy
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH_BYTES);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

   assign set_txrdy = pop;
   assign set_rxrdy = push;

   always_comb begin
      buf_e   = buf_h;
      tx_e    = tx_h;
      rx_e    = rx_h;
      tx_data = '0;
      set_udf = 1'b0;
      set_ovr = 1'b0;
      for (int k = 0; k < DEPTH_BYTES; k++) begin
         if (tx_h == CNT_W'(k + 1)) tx_data = buf_h[k*BYTE_W +: BYTE_W];
      end
      if (pop) begin
         if (tx_h == '0) set_udf = 1'b1;
         else            tx_e    = tx_h - ONE_C;
      end
      if (push) begin
         if (rx_h < DEPTH_C) begin
            for (int k = 0; k < DEPTH_BYTES; k++) begin
               if (rx_h == CNT_W'(k)) buf_e[k*BYTE_W +: BYTE_W] = push_data;
            end
            rx_e = rx_h + ONE_C;
         end else begin
            set_ovr = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bpb_status_flags.sv
module bpb_status_flags
   import bpb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_udf,
   input  logic       clr_udf,
   input  logic       set_ovr,
   input  logic       clr_ovr,
   input  logic       set_txrdy,
   input  logic       clr_txrdy,
   input  logic       set_rxrdy,
   input  logic       clr_rxrdy,
   input  logic       short_rd,
   output bpb_flags_t flags_q,
   output logic       single_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q  <= '0;
         single_q <= 1'b0;
      end else begin
         flags_q.tx_underflow <= set_udf   | (flags_q.tx_underflow & ~clr_udf);
         flags_q.rx_overrun   <= set_ovr   | (flags_q.rx_overrun   & ~clr_ovr);
         flags_q.tx_ready     <= set_txrdy | (flags_q.tx_ready     & ~clr_txrdy);
         flags_q.rx_ready     <= set_rxrdy | (flags_q.rx_ready     & ~clr_rxrdy);
         single_q             <= short_rd;
      end
   end
endmodule

// File: rtl/bpb_buffer.sv
module bpb_buffer
   import bpb_pkg::*;
#(
   parameter int BYTE_W         = 8,
   parameter int HOST_BYTES     = 2,
   parameter int DEPTH_BYTES    = 4,
   parameter bit BIG_ENDIAN_OPT = 1'b1,
   localparam int HOST_W        = BYTE_W * HOST_BYTES,
   localparam int CNT_W         = $clog2(DEPTH_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian,
   input  logic              host_wr,
   input  logic              host_wr_byte,
   input  logic [HOST_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [HOST_W-1:0] host_rdata,
   input  logic              eng_tx_pop,
   output logic [BYTE_W-1:0] eng_tx_data,
   input  logic              eng_rx_push,
   input  logic [BYTE_W-1:0] eng_rx_data,
   output logic [CNT_W-1:0]  tx_count,
   output logic [CNT_W-1:0]  rx_count,
   output logic              tx_underflow,
   output logic              rx_overrun,
   output logic              tx_ready,
   output logic              rx_ready,
   output logic              rd_single
);
   localparam int BUF_W = BYTE_W * DEPTH_BYTES;

   generate
      if (BYTE_W < 1) begin : g_bad_byte
         $error("BYTE_W must be at least 1");
      end
      if (HOST_BYTES < 1) begin : g_bad_host
         $error("HOST_BYTES must be at least 1");
      end
      if (DEPTH_BYTES < 2 * HOST_BYTES) begin : g_bad_depth
         $error("DEPTH_BYTES must hold two host words");
      end
   endgenerate

   logic [BUF_W-1:0]  buf_q, buf_h, buf_e;
   logic [CNT_W-1:0]  tx_q, tx_h, tx_e;
   logic [CNT_W-1:0]  rx_q, rx_h, rx_e;
   logic [HOST_W-1:0] word_sw;
   logic              wr_swap, rd_swap;
   bpb_host_op_e      op;
   logic clr_udf, clr_txrdy, clr_ovr, clr_rxrdy, short_rd;
   logic set_udf, set_ovr, set_txrdy, set_rxrdy;
   bpb_flags_t        flags_q;

   generate
      if (BIG_ENDIAN_OPT) begin : g_order_sel
         assign wr_swap = ~big_endian;
         assign rd_swap = big_endian;
      end else begin : g_order_fixed
         logic unused_order;
         assign unused_order = big_endian;
         assign wr_swap = 1'b1;
         assign rd_swap = 1'b0;
      end
   endgenerate

   always_comb begin
      if (host_wr)      op = host_wr_byte ? HOP_BYTE : HOP_WORD;
      else if (host_rd) op = HOP_READ;
      else              op = HOP_NONE;
   end

   bpb_order_swap #(.BYTE_W(BYTE_W), .LANES(HOST_BYTES)) u_wr_swap (
      .din(host_wdata), .swap(wr_swap), .dout(word_sw)
   );

   bpb_order_swap #(.BYTE_W(BYTE_W), .LANES(HOST_BYTES)) u_rd_swap (
      .din(buf_q[HOST_W-1:0]), .swap(rd_swap), .dout(host_rdata)
   );

   bpb_host_stage #(
      .BYTE_W(BYTE_W), .HOST_BYTES(HOST_BYTES),
      .DEPTH_BYTES(DEPTH_BYTES), .CNT_W(CNT_W)
   ) u_host (
      .op(op), .word_in(word_sw), .byte_in(host_wdata[BYTE_W-1:0]),
      .buf_q(buf_q), .tx_q(tx_q), .rx_q(rx_q),
      .buf_h(buf_h), .tx_h(tx_h), .rx_h(rx_h),
      .clr_udf(clr_udf), .clr_txrdy(clr_txrdy), .clr_ovr(clr_ovr),
      .clr_rxrdy(clr_rxrdy), .short_rd(short_rd)
   );

   bpb_engine_stage #(
      .BYTE_W(BYTE_W), .DEPTH_BYTES(DEPTH_BYTES), .CNT_W(CNT_W)
   ) u_eng (
      .pop(eng_tx_pop), .push(eng_rx_push), .push_data(eng_rx_data),
      .buf_h(buf_h), .tx_h(tx_h), .rx_h(rx_h),
      .buf_e(buf_e), .tx_e(tx_e), .rx_e(rx_e), .tx_data(eng_tx_data),
      .set_udf(set_udf), .set_ovr(set_ovr),
      .set_txrdy(set_txrdy), .set_rxrdy(set_rxrdy)
   );

   bpb_status_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_udf(set_udf), .clr_udf(clr_udf),
      .set_ovr(set_ovr), .clr_ovr(clr_ovr),
      .set_txrdy(set_txrdy), .clr_txrdy(clr_txrdy),
      .set_rxrdy(set_rxrdy), .clr_rxrdy(clr_rxrdy),
      .short_rd(short_rd), .flags_q(flags_q), .single_q(rd_single)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         tx_q  <= '0;
         rx_q  <= '0;
      end else begin
         buf_q <= buf_e;
         tx_q  <= tx_e;
         rx_q  <= rx_e;
      end
   end

   assign tx_count     = tx_q;
   assign rx_count     = rx_q;
   assign tx_underflow = flags_q.tx_underflow;
   assign rx_overrun   = flags_q.rx_overrun;
   assign tx_ready     = flags_q.tx_ready;
   assign rx_ready     = flags_q.rx_ready;
endmodule

// File: rtl/bpb_buffer_chk.sv
module bpb_buffer_chk #(
   parameter int DEPTH_BYTES = 4,
   parameter int HOST_BYTES  = 2,
   localparam int CNT_W      = $clog2(DEPTH_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic             host_rd,
   input logic             eng_tx_pop,
   input logic             eng_rx_push,
   input logic [CNT_W-1:0] tx_count,
   input logic [CNT_W-1:0] rx_count,
   input logic             tx_underflow,
   input logic             rx_overrun,
   input logic             tx_ready,
   input logic             rx_ready,
   input logic             rd_single
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH_BYTES);
   localparam logic [CNT_W-1:0] LIM_C   = CNT_W'(DEPTH_BYTES - HOST_BYTES);
   localparam logic [CNT_W-1:0] HB_C    = CNT_W'(HOST_BYTES);

   // R6: neither side ever counts past the storage depth
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count <= DEPTH_C) && (rx_count <= DEPTH_C));

   p_write_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && (tx_count > LIM_C) && !eng_tx_pop |=> $stable(tx_count));

   p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_tx_pop && (tx_count == '0) && !host_wr |=> tx_underflow);

   p_pop_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_tx_pop |=> tx_ready);

   p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rx_push && (rx_count == DEPTH_C) && !host_rd && !host_wr |=> rx_overrun);

   p_short_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !host_wr && !eng_rx_push && (rx_count == CNT_W'(1))
      |=> rd_single && (rx_count == '0));

   p_read_clr_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !host_wr && !eng_rx_push |=> !rx_overrun);

   p_read_clr_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !host_wr && !eng_rx_push && (rx_count <= HB_C) |=> !rx_ready);
endmodule

bind bpb_buffer bpb_buffer_chk #(
   .DEPTH_BYTES(DEPTH_BYTES), .HOST_BYTES(HOST_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
   .tx_count(tx_count), .rx_count(rx_count),
   .tx_underflow(tx_underflow), .rx_overrun(rx_overrun),
   .tx_ready(tx_ready), .rx_ready(rx_ready), .rd_single(rd_single)
);

// File: tb/tb_bpb_buffer.sv
module tb_bpb_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_endian = 1'b0;
   logic        host_wr = 1'b0, host_wr_byte = 1'b0, host_rd = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
   logic [7:0]  eng_rx_data = '0;
   logic [7:0]  eng_tx_data;
   logic [2:0]  tx_count, rx_count;
   logic        tx_underflow, rx_overrun, tx_ready, rx_ready, rd_single;

   int checks = 0;
   int fails  = 0;
   logic [15:0] cap_rd;
   logic [7:0]  cap_tx;

   always #10 clk = ~clk;

   bpb_buffer dut (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
      .host_wr(host_wr), .host_wr_byte(host_wr_byte), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .tx_count(tx_count), .rx_count(rx_count),
      .tx_underflow(tx_underflow), .rx_overrun(rx_overrun),
      .tx_ready(tx_ready), .rx_ready(rx_ready), .rd_single(rd_single)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive one cycle of stimulus right after a falling edge, capture the
   // combinational outputs before the rising edge, release after it.
   task automatic cyc(input logic wr, input logic wb, input logic [15:0] wd,
                      input logic rd, input logic pop, input logic push,
                      input logic [7:0] pd);
      host_wr = wr; host_wr_byte = wb; host_wdata = wd; host_rd = rd;
      eng_tx_pop = pop; eng_rx_push = push; eng_rx_data = pd;
      #2;
      cap_rd = host_rdata;
      cap_tx = eng_tx_data;
      @(negedge clk);
      host_wr = 1'b0; host_wr_byte = 1'b0; host_rd = 1'b0;
      eng_tx_pop = 1'b0; eng_rx_push = 1'b0;
   endtask

   task automatic wr_word(input logic [15:0] d); cyc(1, 0, d, 0, 0, 0, 8'h00); endtask
   task automatic wr_byte(input logic [15:0] d); cyc(1, 1, d, 0, 0, 0, 8'h00); endtask
   task automatic pop1();                        cyc(0, 0, 16'h0, 0, 1, 0, 8'h00); endtask
   task automatic push1(input logic [7:0] d);    cyc(0, 0, 16'h0, 0, 0, 1, d); endtask
   task automatic rd1();                         cyc(0, 0, 16'h0, 1, 0, 0, 8'h00); endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      check("R11 tx_count", tx_count, 0);
      check("R11 rx_count", rx_count, 0);
      check("R11 flags", {tx_underflow, rx_overrun, tx_ready, rx_ready, rd_single}, 0);
      check("R11 rdata", host_rdata, 0);
   endtask

   task automatic t_word_le();
      do_reset(); big_endian = 1'b0;
      wr_word(16'hBBAA);
      check("R1 count after word", tx_count, 2);
      pop1(); check("R1 first pop le", cap_tx, 8'hAA);
      check("R4 count after pop", tx_count, 1);
      pop1(); check("R1 second pop le", cap_tx, 8'hBB);
      pop1(); check("R4 empty pop data", cap_tx, 0);
      check("R4 underflow", tx_underflow, 1);
      check("R4 count stays 0", tx_count, 0);
      check("R5 pop sets tx_ready", tx_ready, 1);
      wr_word(16'h0102);
      check("R5 write clears underflow", tx_underflow, 0);
      check("R5 tx_ready kept at count 2", tx_ready, 1);
   endtask

   task automatic t_word_be();
      do_reset(); big_endian = 1'b1;
      wr_word(16'h1234);
      pop1(); check("R1 first pop be", cap_tx, 8'h12);
      pop1(); check("R1 second pop be", cap_tx, 8'h34);
      big_endian = 1'b0;
   endtask

   task automatic t_drop();
      do_reset(); big_endian = 1'b0;
      wr_word(16'h2211);
      pop1(); check("R1 pop before refill", cap_tx, 8'h11);
      wr_word(16'h4433);
      check("R1 count 3", tx_count, 3);
      check("R5 tx_ready cleared above 2", tx_ready, 0);
      wr_word(16'h6655);
      check("R2 word dropped count", tx_count, 3);
      wr_byte(16'h0077);
      check("R2 byte dropped count", tx_count, 3);
      pop1(); check("R2 data kept 0", cap_tx, 8'h22);
      pop1(); check("R2 data kept 1", cap_tx, 8'h33);
      pop1(); check("R2 data kept 2", cap_tx, 8'h44);
      check("R4 drained", tx_count, 0);
   endtask

   task automatic t_byte();
      do_reset(); big_endian = 1'b0;
      wr_word(16'h2211);
      wr_byte(16'hEE33);
      check("R3 count after byte", tx_count, 3);
      pop1(); check("R3 pop 0", cap_tx, 8'h11);
      pop1(); check("R3 pop 1", cap_tx, 8'h22);
      pop1(); check("R3 last byte", cap_tx, 8'h33);
   endtask

   task automatic t_rx();
      do_reset(); big_endian = 1'b0;
      push1(8'hA1); push1(8'hA2); push1(8'hA3);
      check("R6 rx_count 3", rx_count, 3);
      check("R6 rx_ready set", rx_ready, 1);
      rd1();
      check("R7 read le", cap_rd, 16'hA2A1);
      check("R8 count 3 to 1", rx_count, 1);
      check("R9 rx_ready kept", rx_ready, 1);
      rd1();
      check("R7 odd byte", cap_rd[7:0], 8'hA3);
      check("R8 count 1 to 0", rx_count, 0);
      check("R8 single pulse", rd_single, 1);
      check("R9 rx_ready cleared", rx_ready, 0);
      rd1();
      check("R8 single pulse ends", rd_single, 0);
      check("R8 read at 0", rx_count, 0);
   endtask

   task automatic t_rx_be();
      do_reset(); big_endian = 1'b1;
      push1(8'h5A); push1(8'hC3);
      rd1();
      check("R7 read be", cap_rd, 16'h5AC3);
      check("R8 count 2 to 0", rx_count, 0);
      check("R8 no pulse for pair", rd_single, 0);
      check("R9 rx_ready cleared be", rx_ready, 0);
      big_endian = 1'b0;
   endtask

   task automatic t_ovr();
      do_reset(); big_endian = 1'b0;
      push1(8'h11); push1(8'h22); push1(8'h33); push1(8'h44);
      check("R6 no overrun at fill", rx_overrun, 0);
      push1(8'h55);
      check("R6 overrun", rx_overrun, 1);
      check("R6 count held 4", rx_count, 4);
      rd1();
      check("R7 full read", cap_rd, 16'h2211);
      check("R9 read clears overrun", rx_overrun, 0);
      check("R8 count 4 to 2", rx_count, 2);
      rd1();
      check("R6 lost byte absent", cap_rd, 16'h4433);
      check("R9 empty after pairs", rx_ready, 0);
   endtask

   task automatic t_same_cycle();
      do_reset(); big_endian = 1'b0;
      cyc(1, 0, 16'hBBAA, 0, 1, 0, 8'h00);
      check("R10 pop after write data", cap_tx, 8'hAA);
      check("R10 pop after write count", tx_count, 1);
      check("R10 no underflow", tx_underflow, 0);
      push1(8'h01); push1(8'h02); push1(8'h03); push1(8'h04);
      cyc(0, 0, 16'h0, 1, 0, 1, 8'h05);
      check("R10 read before push data", cap_rd, 16'h0201);
      check("R10 push after read count", rx_count, 3);
      check("R10 no overrun", rx_overrun, 0);
      rd1();
      check("R10 shifted pair", cap_rd, 16'h0403);
      rd1();
      check("R10 pushed byte", cap_rd[7:0], 8'h05);
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_word_le();
      t_word_be();
      t_drop();
      t_byte();
      t_rx();
      t_rx_be();
      t_ovr();
      t_same_cycle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule